// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. A 2-bit select input picks the conversion-clock source: the system clock divided by 2, 8 or 32, or a free-running internal RC oscillator. The RC input is asynchronous, so it is brought in through a synchronizer. Software starts a conversion by writing 1 to the start/busy bit. The block then isolates the sample-and-hold and presents trial codes to an external DAC on `dac_code`. On each conversion-clock period it reads the `cmp_in` comparator input and keeps or drops one trial bit, from the most significant bit down to the least.

At the end of a conversion, one clock edge loads the 2-bit high and 8-bit low result registers, clears busy, sets a sticky completion flag and reconnects the sample-and-hold. The flag drives an interrupt request when its enable is set. While the core is asleep, the same request also drives a wake output. When the system clock is stopped (sleep), only the RC source can carry a conversion to its end.

Top module: `adc_sar_sequencer`

## Requirements
- R1: With `sel` = 00, 01 or 10, one conversion-clock period lasts N = 2, 8 or 32 system cycles. The period count restarts at the start write. Busy clears exactly 11·N rising clock edges after the edge that captured the start write.
- R2: With `sel` = 11, each conversion-clock period is bounded by rising edges of `rc_clk`, passed through a two-stage synchronizer. The conversion ends after 11 such edges.
- R3: `dac_code` is 10'h200 right after the start. `cmp_in` = 1 keeps the current trial bit and `cmp_in` = 0 clears it. When `cmp_in` = (`dac_code` <= V), the result equals V for every 10-bit V.
- R4: `sh_connect` is 1 when idle. It drops at the end of the first conversion-clock period and stays low while busy, for 10·N system cycles with divided sources. It returns to 1 on the same edge that clears busy.
- R5: On completion, a single edge loads the result, clears `busy`, sets `done_flag` and sets `sh_connect`.
- R6: `done_flag` is set at every completion, whatever the value of `int_en`. Only a `clr_flag` pulse clears it.
- R7: `irq` = `done_flag` AND `int_en`. `wake` = `irq` AND `sleep`.
- R8: While `sleep` = 1 with a divided source selected, the conversion does not advance. `busy` stays 1 and `dac_code` holds. Progress resumes after sleep and the total active period count is unchanged.
- R9: A start write (`wr_en`=1, `wr_go`=1) during a busy conversion is ignored, and the completion time is unchanged.
- R10: A write of `wr_go`=0 while busy aborts the conversion. `busy` is 0 and `sh_connect` is 1 at the next edge. The result registers and `done_flag` stay unchanged.
- R11: The result is right-justified: `res_hi` = result[9:8] and `res_lo` = result[7:0]. Both change only on a completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 2 | Conversion-clock select (00 /2, 01 /8, 10 /32, 11 RC) |
| rc_clk | input | 1 | Asynchronous internal RC oscillator |
| sleep | input | 1 | Core sleep; divided sources are frozen while high |
| wr_en | input | 1 | Write strobe for the start/busy bit |
| wr_go | input | 1 | Value written to the start/busy bit |
| clr_flag | input | 1 | Software clear of the completion flag |
| int_en | input | 1 | Completion interrupt enable |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| busy | output | 1 | Start/busy bit readback |
| sh_connect | output | 1 | Sample-and-hold connected to the analog input |
| dac_code | output | 10 | Trial code for the external DAC |
| res_hi | output | 2 | Result bits 9:8 |
| res_lo | output | 8 | Result bits 7:0 |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request to a sleeping core |

## Verification
The assertions assume that `wr_en` writes, `clr_flag` pulses and completion events never fall on the same edge. They also assume that `sel` stays constant while a conversion is busy. The stimulus keeps to this: it changes `sel` only when idle, and it issues clears and aborts only when no completion can be due. `cmp_in` is derived combinationally from `dac_code` and a target value held in the bench, which models an ideal comparator settling within a cycle. The RC oscillator runs at a period unrelated to the system clock, so that the synchronizer sees arbitrary phases.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  typedef enum logic [1:0] {
    CSEL_DIV_A = 2'b00,
    CSEL_DIV_B = 2'b01,
    CSEL_DIV_C = 2'b10,
    CSEL_RC    = 2'b11
  } csel_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_conv_clk.sv
module adc_conv_clk
  import adc_sar_pkg::*;
#(
  parameter int unsigned DIV_A       = 2,
  parameter int unsigned DIV_B       = 8,
  parameter int unsigned DIV_C       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       run,
  input  logic       sleep,
  input  logic       rc_clk,
  output logic       conv_tick
);

  localparam int unsigned DIV_MAX = max3(DIV_A, DIV_B, DIV_C);
  localparam int unsigned CW      = $clog2(DIV_MAX);

  logic [CW-1:0]          cnt_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rc_prev_q;
  logic                   rc_sel;
  logic                   sys_tick;
  logic                   rc_tick;
  logic [CW-1:0]          term;

  function automatic logic [CW-1:0] term_of(input logic [1:0] s);
    case (csel_e'(s))
      CSEL_DIV_A: return CW'(DIV_A - 1);
      CSEL_DIV_B: return CW'(DIV_B - 1);
      default:    return CW'(DIV_C - 1);
    endcase
  endfunction

  assign rc_sel = (csel_e'(sel) == CSEL_RC);
  assign term   = term_of(sel);

  // RC oscillator synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= rc_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_prev_q <= 1'b0;
    else        rc_prev_q <= sync_q[SYNC_STAGES-1];
  end

  // system-clock divider, restarted whenever idle, frozen during sleep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run)             cnt_q <= '0;
    else if (sleep || rc_sel)  cnt_q <= cnt_q;
    else if (cnt_q >= term)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign sys_tick  = run && !sleep && !rc_sel && (cnt_q == term);
  assign rc_tick   = run && rc_sel && sync_q[SYNC_STAGES-1] && !rc_prev_q;
  assign conv_tick = sys_tick || rc_tick;

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned RES_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_go,
  input  logic                      conv_tick,
  input  logic                      cmp_in,
  output logic                      busy,
  output logic                      sh_connect,
  output logic [RES_W-1:0]          dac_code,
  output logic                      done_evt,
  output logic                      abort_evt,
  output logic [RES_W-1:0]          result_next,
  output logic [$clog2(RES_W+2)-1:0] step
);

  localparam int unsigned SW = $clog2(RES_W + 2);
  localparam logic [SW-1:0] LAST_STEP = SW'(RES_W);
  localparam logic [RES_W-1:0] MSB_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  logic          start_evt;
  logic          resolving;
  logic [SW-1:0] bit_idx;

  // decide one trial bit and place the next trial bit below it
  function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] code,
                                                input logic [SW-1:0] idx,
                                                input logic keep);
    logic [RES_W-1:0] out;
    out = code;
    out[idx] = keep;
    if (idx != '0) out[idx - 1'b1] = 1'b1;
    return out;
  endfunction

  assign start_evt   = wr_en && wr_go && !busy;
  assign abort_evt   = wr_en && !wr_go && busy;
  assign resolving   = busy && conv_tick && (step != '0);
  assign bit_idx     = LAST_STEP - step;
  assign result_next = sar_step(dac_code, bit_idx, cmp_in);
  assign done_evt    = resolving && (step == LAST_STEP) && !abort_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sh_connect <= 1'b1;
      dac_code   <= '0;
      step       <= '0;
    end else if (start_evt) begin
      busy       <= 1'b1;
      dac_code   <= MSB_TRIAL;
      step       <= '0;
    end else if (abort_evt || done_evt) begin
      busy       <= 1'b0;
      sh_connect <= 1'b1;
      step       <= '0;
      if (done_evt) dac_code <= result_next;
    end else if (busy && conv_tick) begin
      step <= step + 1'b1;
      if (step == '0) sh_connect <= 1'b0;
      else            dac_code   <= result_next;
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned LO_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_evt,
  input  logic [RES_W-1:0]      result_in,
  input  logic                  clr_flag,
  input  logic                  int_en,
  input  logic                  sleep,
  output logic [RES_W-LO_W-1:0] res_hi,
  output logic [LO_W-1:0]       res_lo,
  output logic                  done_flag,
  output logic                  irq,
  output logic                  wake
);

  localparam int unsigned HI_W = RES_W - LO_W;

  function automatic logic [HI_W-1:0] hi_part(input logic [RES_W-1:0] r);
    return r[RES_W-1:LO_W];
  endfunction

  function automatic logic [LO_W-1:0] lo_part(input logic [RES_W-1:0] r);
    return r[LO_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
    end else if (done_evt) begin
      res_hi <= hi_part(result_in);
      res_lo <= lo_part(result_in);
    end
  end

  // completion wins over a simultaneous software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (done_evt) done_flag <= 1'b1;
    else if (clr_flag) done_flag <= 1'b0;
  end

  assign irq  = done_flag && int_en;
  assign wake = irq && sleep;

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned LO_W        = 8,
  parameter int unsigned DIV_A       = 2,
  parameter int unsigned DIV_B       = 8,
  parameter int unsigned DIV_C       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            sel,
  input  logic                  rc_clk,
  input  logic                  sleep,
  input  logic                  wr_en,
  input  logic                  wr_go,
  input  logic                  clr_flag,
  input  logic                  int_en,
  input  logic                  cmp_in,
  output logic                  busy,
  output logic                  sh_connect,
  output logic [RES_W-1:0]      dac_code,
  output logic [RES_W-LO_W-1:0] res_hi,
  output logic [LO_W-1:0]       res_lo,
  output logic                  done_flag,
  output logic                  irq,
  output logic                  wake
);

  localparam int unsigned SW = $clog2(RES_W + 2);

  logic             conv_tick;
  logic             done_evt;
  logic             abort_evt;
  logic [RES_W-1:0] result_next;
  logic [SW-1:0]    step;

  adc_conv_clk #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(SYNC_STAGES)
  ) u_clk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .run(busy), .sleep(sleep),
    .rc_clk(rc_clk), .conv_tick(conv_tick)
  );

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_go(wr_go),
    .conv_tick(conv_tick), .cmp_in(cmp_in), .busy(busy),
    .sh_connect(sh_connect), .dac_code(dac_code), .done_evt(done_evt),
    .abort_evt(abort_evt), .result_next(result_next), .step(step)
  );

  adc_result_bank #(.RES_W(RES_W), .LO_W(LO_W)) u_res (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .result_in(result_next),
    .clr_flag(clr_flag), .int_en(int_en), .sleep(sleep), .res_hi(res_hi),
    .res_lo(res_lo), .done_flag(done_flag), .irq(irq), .wake(wake)
  );

endmodule

// File: rtl/adc_sar_checker.sv
module adc_sar_checker #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned LO_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            sel,
  input logic                  sleep,
  input logic                  wr_en,
  input logic                  wr_go,
  input logic                  clr_flag,
  input logic                  busy,
  input logic                  sh_connect,
  input logic [RES_W-1:0]      dac_code,
  input logic [RES_W-LO_W-1:0] res_hi,
  input logic [LO_W-1:0]       res_lo,
  input logic                  done_flag,
  input logic                  irq,
  input logic                  wake,
  input logic                  conv_tick,
  input logic                  done_evt
);

  AST_DONE_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && done_flag && sh_connect)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_flag) |=> done_flag); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable({res_hi, res_lo})); // R11

  AST_NO_SYS_TICK_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && sel != 2'b11) |-> !conv_tick); // R8

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sleep && sel != 2'b11 && !wr_en) |=> (busy && $stable(dac_code))); // R8

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_tick && !done_evt && !wr_en) |=> !sh_connect); // R4

  AST_IDLE_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sh_connect); // R4

  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_go && !done_evt) |=> busy); // R9

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !wr_go && !clr_flag) |=>
      (!busy && sh_connect && $stable(done_flag) && $stable({res_hi, res_lo}))); // R10

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (sleep && irq)); // R7

endmodule

bind adc_sar_sequencer adc_sar_checker #(.RES_W(RES_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sleep(sleep), .wr_en(wr_en),
  .wr_go(wr_go), .clr_flag(clr_flag), .busy(busy), .sh_connect(sh_connect),
  .dac_code(dac_code), .res_hi(res_hi), .res_lo(res_lo),
  .done_flag(done_flag), .irq(irq), .wake(wake), .conv_tick(conv_tick),
  .done_evt(done_evt)
);

// File: tb/adc_sar_sequencer_bench.sv
`timescale 1ns/1ps
module adc_sar_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       rc_clk = 1'b0;
  logic       sleep = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_go = 1'b0;
  logic       clr_flag = 1'b0;
  logic       int_en = 1'b0;
  logic       cmp_in;
  logic       busy, sh_connect, done_flag, irq, wake;
  logic [9:0] dac_code;
  logic [1:0] res_hi;
  logic [7:0] res_lo;
  logic [9:0] target = 10'd0;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always #37 rc_clk = ~rc_clk;

  // ideal comparator: input at or above the DAC level
  assign cmp_in = (dac_code <= target);

  adc_sar_sequencer u_adc_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rc_clk(rc_clk), .sleep(sleep),
    .wr_en(wr_en), .wr_go(wr_go), .clr_flag(clr_flag), .int_en(int_en),
    .cmp_in(cmp_in), .busy(busy), .sh_connect(sh_connect), .dac_code(dac_code),
    .res_hi(res_hi), .res_lo(res_lo), .done_flag(done_flag), .irq(irq), .wake(wake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input logic [1:0] s);
    return (s == 2'b00) ? 2 : (s == 2'b01) ? 8 : 32;
  endfunction

  task automatic write_go(input logic v);
    wr_en = 1'b1; wr_go = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_go = 1'b0;
  endtask

  task automatic pulse_clear();
    clr_flag = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_flag = 1'b0;
  endtask

  // start, then count edges until busy reads low; count cycles sh is open
  task automatic run_conv(input logic [1:0] s, input logic [9:0] t,
                          output int cyc, output int opn);
    sel = s; target = t;
    write_go(1'b1);
    cyc = 0; opn = 0;
    while (busy && cyc < 5000) begin
      if (!sh_connect) opn++;
      @(posedge clk); cyc++; @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cyc, opn;
    logic [9:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && sh_connect && !done_flag && !irq && !wake &&
          {res_hi, res_lo} == 10'd0, "reset state", {busy, sh_connect, done_flag}, 3'b010);

    // R3 R1 R4 R11: full sweep of every code with the /2 source
    for (int v = 0; v < 1024; v++) begin
      run_conv(2'b00, 10'(v), cyc, opn);
      check({res_hi, res_lo} == 10'(v), "R3 result", {res_hi, res_lo}, v);
      check(res_hi == 2'(v >> 8) && res_lo == 8'(v), "R11 split", res_hi, v >> 8);
      check(cyc == 22, "R1 div2 length", cyc, 22);
      check(opn == 20, "R4 hold open cycles", opn, 20);
      check(done_flag && !irq, "R6 flag without enable", {done_flag, irq}, 2'b10);
    end

    // R1 R5: other divided sources
    for (int s = 1; s < 3; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [9:0] v;
        v = 10'(k * 341 + s * 7);
        pulse_clear();
        check(!done_flag, "R6 software clear", done_flag, 0);
        run_conv(2'(s), v, cyc, opn);
        check(cyc == 11 * ratio(2'(s)), "R1 divided length", cyc, 11 * ratio(2'(s)));
        check(opn == 10 * ratio(2'(s)), "R4 hold open cycles", opn, 10 * ratio(2'(s)));
        check(done_flag && sh_connect && !busy && {res_hi, res_lo} == v,
              "R5 completion", {res_hi, res_lo}, v);
      end
    end

    // R7: interrupt and wake gating
    int_en = 1'b1; @(negedge clk);
    check(irq && !wake, "R7 irq awake", {irq, wake}, 2'b10);
    sleep = 1'b1; @(negedge clk);
    check(irq && wake, "R7 wake asleep", {irq, wake}, 2'b11);
    sleep = 1'b0; int_en = 1'b0; @(negedge clk);
    check(!irq && !wake, "R7 irq disabled", {irq, wake}, 2'b00);
    pulse_clear();
    repeat (5) @(negedge clk);
    check(!done_flag, "R6 stays clear", done_flag, 0);

    // R8: sleep freezes a /2 conversion
    sel = 2'b00; target = 10'd777;
    write_go(1'b1);
    cyc = 0;
    repeat (5) begin @(posedge clk); cyc++; @(negedge clk); end
    sleep = 1'b1;
    prev = dac_code;
    repeat (50) begin @(posedge clk); cyc++; @(negedge clk); end
    check(busy && dac_code == prev, "R8 frozen in sleep", dac_code, prev);
    sleep = 1'b0;
    while (busy && cyc < 5000) begin @(posedge clk); cyc++; @(negedge clk); end
    check(cyc == 72, "R8 resumed length", cyc, 72);
    check({res_hi, res_lo} == 10'd777, "R8 result", {res_hi, res_lo}, 777);

    // R9: restart request while busy is ignored
    sel = 2'b01; target = 10'd300;
    write_go(1'b1);
    cyc = 0;
    repeat (19) begin @(posedge clk); cyc++; @(negedge clk); end
    write_go(1'b1); cyc++;
    while (busy && cyc < 5000) begin @(posedge clk); cyc++; @(negedge clk); end
    check(cyc == 88, "R9 length unchanged", cyc, 88);
    check({res_hi, res_lo} == 10'd300, "R9 result", {res_hi, res_lo}, 300);

    // R10: abort leaves result and flag untouched
    pulse_clear();
    sel = 2'b01; target = 10'd55;
    write_go(1'b1);
    repeat (30) @(negedge clk);
    write_go(1'b0);
    check(!busy && sh_connect, "R10 abort state", {busy, sh_connect}, 2'b01);
    repeat (300) @(negedge clk);
    check({res_hi, res_lo} == 10'd300, "R10 result kept", {res_hi, res_lo}, 300);
    check(!done_flag, "R10 flag kept", done_flag, 0);

    // R2: RC source completes while the core sleeps
    sleep = 1'b1; int_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [9:0] v;
      v = 10'(k * 199 + 13);
      pulse_clear();
      run_conv(2'b11, v, cyc, opn);
      check(!busy && {res_hi, res_lo} == v, "R2 RC result in sleep", {res_hi, res_lo}, v);
      check(cyc > 60 && cyc < 120, "R2 RC length", cyc, 88);
      check(done_flag && wake, "R7 wake after RC completion", {done_flag, wake}, 2'b11);
    end
    sleep = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule